// File: doc/BRIEF.md
# General-Purpose Port Register with Peripheral Override

This block is one 8-bit general-purpose I/O port of a small microcontroller. It holds an output latch that the processor bus writes a byte at a time or a single bit at a time. It drives each pad from that latch, unless a routing stage outside the block has handed the pad to a peripheral. In that case the peripheral's data drives the pad and the latch keeps whatever was last written to it.

The read value depends on the kind of access. A plain read returns the live pad levels, even on pads a peripheral owns. A read that the bus marks as read-modify-write returns the latch instead, so that logical and arithmetic operations and bit operations on the port modify the stored value and not whatever the pads happen to show. A read-modify-write is a latch read in one cycle followed by a write in the next cycle.

A two-bit configuration register enables the peripheral routing globally and can switch off all weak pullups. Pads in analog mode read as zero, have their output driver off and get no pullup.

Top module: `pio_port`

## Requirements
- R1: After reset the latch holds all ones and the configuration holds zero. The pads then follow the latch whatever `periphSel` is, and `pullupEn` is high on every pad that is not in analog mode.
- R2: A byte write (`busWrByte`) loads `busWrData` into the latch at the next clock edge. Without a write strobe the latch keeps its value.
- R3: A bit write (`busWrBit`) loads `busWrData[0]` into latch bit `busBitSel` at the next clock edge and leaves the other bits unchanged. When both write strobes are high, the byte write wins.
- R4: A plain read (`busRd` high, `busRmw` low) returns `pinIn`, not the latch. This holds also for pads assigned to a peripheral.
- R5: A pad with `analogSel` set reads as 0 on a plain read and has `padOe` low, `padOut` low and `pullupEn` low.
- R6: A read with `busRmw` high returns the latch contents whatever the pad levels are. A read-modify-write is done as this latch read followed by a byte write in the next cycle.
- R7: With the crossbar enabled, a pad whose `periphSel` bit is set drives `periphOut` for that bit. Writes still update the latch, and a read-modify-write read shows the updated latch.
- R8: With the crossbar disabled, every non-analog pad drives its latch bit whatever `periphSel` and `periphOut` are.
- R9: With the pullup-disable bit at 1, `pullupEn` is 0 on every pad. With it at 0, `pullupEn` is 1 on every pad except the analog ones.
- R10: `cfgWr` loads the configuration at the next clock edge. `busWrData` bit 0 is the crossbar enable and bit 1 is the pullup disable.
- R11: `busRdData` is 0 in any cycle where `busRd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrByte | input | 1 | Byte write strobe for the latch |
| busWrBit | input | 1 | Single-bit write strobe for the latch |
| busBitSel | input | 3 | Bit index for a bit write |
| busWrData | input | 8 | Write data (bit 0 for bit writes, bits 1:0 for config) |
| cfgWr | input | 1 | Configuration write strobe |
| busRd | input | 1 | Read strobe |
| busRmw | input | 1 | Marks the read as the read half of a read-modify-write |
| busRdData | output | 8 | Read data |
| pinIn | input | 8 | Live pad input levels |
| periphSel | input | 8 | Per-pad peripheral assignment from the routing stage |
| periphOut | input | 8 | Peripheral output data per pad |
| analogSel | input | 8 | Per-pad analog mode |
| padOut | output | 8 | Pad output value |
| padOe | output | 8 | Pad output driver enable |
| pullupEn | output | 8 | Weak pullup enable per pad |

## Verification
The bench builds the block with its default parameters: an 8-pad port whose latch resets to all ones. With this width, a single vector table covers every mix of latch value, pad level and analog mask in one byte, and each bit index of a bit write can be reached. The all-ones reset value lets the first bit write show up as one cleared bit among set bits. Configuration changes during the run bring the crossbar on and off and the pullup disable on and off, which gives the combinations of peripheral override and latch output.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Strobes the control half hands to the datapath each cycle
  typedef struct packed {
    logic byteWe;   // full latch load
    logic bitWe;    // single latch bit load
    logic cfgWe;    // configuration load
    logic rdEn;     // a read is in progress
    logic rdLatch;  // read source is the latch, not the pads
  } pioStrobe_t;

  // Configuration field positions within the write data
  localparam int CFG_XBAR_BIT    = 0;
  localparam int CFG_PULLDIS_BIT = 1;
  localparam int CFG_WIDTH       = 2;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrByte,
  input  logic       busWrBit,
  input  logic       cfgWr,
  input  logic       busRd,
  input  logic       busRmw,
  output pioStrobe_t strb
);

  always_comb begin
    strb         = '0;
    strb.byteWe  = busWrByte;
    // a byte write overrides a simultaneous bit write
    strb.bitWe   = busWrBit & ~busWrByte;
    strb.cfgWe   = cfgWr;
    strb.rdEn    = busRd;
    strb.rdLatch = busRd & busRmw;
  end

  // R3: the datapath never sees two latch load strobes at once
  assert_write_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.byteWe, strb.bitWe}));

  // R6: a latch-sourced read is always part of an active read
  assert_latch_read_qualified_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLatch |-> strb.rdEn);

endmodule

// File: rtl/pio_data.sv
module pio_data
  import pio_pkg::*;
#(
  parameter int              WIDTH      = 8,
  parameter logic [WIDTH-1:0] LATCH_INIT = '1,
  localparam int             IDXW       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pioStrobe_t       strb,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] periphSel,
  input  logic [WIDTH-1:0] periphOut,
  input  logic [WIDTH-1:0] analogSel,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] pullupEn
);

  logic [WIDTH-1:0]     latchQ;
  logic [CFG_WIDTH-1:0] cfgQ;
  logic [WIDTH-1:0]     bitMask;
  logic                 xbarOn;
  logic                 pullOff;

  assign bitMask = {{(WIDTH-1){1'b0}}, 1'b1} << bitIdx;
  assign xbarOn  = cfgQ[CFG_XBAR_BIT];
  assign pullOff = cfgQ[CFG_PULLDIS_BIT];

  // Output latch storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= LATCH_INIT;
    end else if (strb.byteWe) begin
      latchQ <= wrData;
    end else if (strb.bitWe) begin
      latchQ <= (latchQ & ~bitMask) | (bitMask & {WIDTH{wrData[0]}});
    end
  end

  // Configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (strb.cfgWe) begin
      cfgQ <= wrData[CFG_WIDTH-1:0];
    end
  end

  // Read source selection
  always_comb begin
    if (!strb.rdEn) begin
      rdData = '0;
    end else if (strb.rdLatch) begin
      rdData = latchQ;
    end else begin
      rdData = pinIn & ~analogSel;
    end
  end

  // Per-pad output muxing and pullup gating
  for (genvar p = 0; p < WIDTH; p++) begin : g_pad
    logic ownedByPeriph;
    assign ownedByPeriph = xbarOn & periphSel[p];
    always_comb begin
      if (analogSel[p]) begin
        padOut[p] = 1'b0;
      end else if (ownedByPeriph) begin
        padOut[p] = periphOut[p];
      end else begin
        padOut[p] = latchQ[p];
      end
    end
    assign padOe[p]    = ~analogSel[p];
    assign pullupEn[p] = ~pullOff & ~analogSel[p];
  end

  // R2: a byte write lands in the latch one edge later
  assert_byte_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteWe |=> latchQ == $past(wrData));

  // R2: without a write strobe the latch holds
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.byteWe && !strb.bitWe) |=> $stable(latchQ));

  // R3: a bit write touches only the selected bit
  assert_bit_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitWe |=> (latchQ[$past(bitIdx)] == $past(wrData[0])) &&
                   ((latchQ & ~$past(bitMask)) == $past(latchQ & ~bitMask)));

  // R5: analog pads read as zero on a pad read
  assert_analog_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !strb.rdLatch) |-> (rdData & analogSel) == '0);

  // R8: after the crossbar is switched off, non-analog pads follow the latch
  assert_xbar_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cfgWe && !wrData[CFG_XBAR_BIT]) |=> ((padOut ^ latchQ) & ~analogSel) == '0);

  // R9: setting the pullup disable clears every pullup enable
  assert_pullup_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cfgWe && wrData[CFG_PULLDIS_BIT]) |=> pullupEn == '0);

endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int              WIDTH      = 8,
  parameter logic [WIDTH-1:0] LATCH_INIT = '1,
  localparam int             IDXW       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrByte,
  input  logic             busWrBit,
  input  logic [IDXW-1:0]  busBitSel,
  input  logic [WIDTH-1:0] busWrData,
  input  logic             cfgWr,
  input  logic             busRd,
  input  logic             busRmw,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] periphSel,
  input  logic [WIDTH-1:0] periphOut,
  input  logic [WIDTH-1:0] analogSel,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] pullupEn
);

  pioStrobe_t strb;

  pio_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrByte (busWrByte),
    .busWrBit  (busWrBit),
    .cfgWr     (cfgWr),
    .busRd     (busRd),
    .busRmw    (busRmw),
    .strb      (strb)
  );

  pio_data #(
    .WIDTH      (WIDTH),
    .LATCH_INIT (LATCH_INIT)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitIdx    (busBitSel),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .pinIn     (pinIn),
    .periphSel (periphSel),
    .periphOut (periphOut),
    .analogSel (analogSel),
    .padOut    (padOut),
    .padOe     (padOe),
    .pullupEn  (pullupEn)
  );

  // R11: no read strobe, no read data
  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdData == '0);

endmodule

// File: tb/pio_port_test.sv
module pio_port_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         busWrByte, busWrBit, cfgWr, busRd, busRmw;
  logic [2:0]   busBitSel;
  logic [W-1:0] busWrData, busRdData, pinIn, periphSel, periphOut, analogSel;
  logic [W-1:0] padOut, padOe, pullupEn;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  pio_port uut (
    .clk(clk), .rstN(rstN),
    .busWrByte(busWrByte), .busWrBit(busWrBit), .busBitSel(busBitSel),
    .busWrData(busWrData), .cfgWr(cfgWr), .busRd(busRd), .busRmw(busRmw),
    .busRdData(busRdData), .pinIn(pinIn), .periphSel(periphSel),
    .periphOut(periphOut), .analogSel(analogSel), .padOut(padOut),
    .padOe(padOe), .pullupEn(pullupEn)
  );

  // {write value, pad levels, analog mask, expected pad read}
  localparam logic [31:0] VEC [6] = '{
    {8'hA5, 8'h3C, 8'h00, 8'h3C},
    {8'h00, 8'hFF, 8'h0F, 8'hF0},
    {8'hFF, 8'h00, 8'h00, 8'h00},
    {8'h5A, 8'hC3, 8'h81, 8'h42},
    {8'h3C, 8'hAA, 8'hF0, 8'h0A},
    {8'h81, 8'h55, 8'h00, 8'h55}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic byteWrite(input logic [W-1:0] v);
    @(negedge clk);
    busWrByte = 1'b1; busWrData = v;
    @(negedge clk);
    busWrByte = 1'b0;
  endtask

  task automatic cfgWrite(input logic [W-1:0] v);
    @(negedge clk);
    cfgWr = 1'b1; busWrData = v;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic readPort(input logic rmw, output logic [W-1:0] v);
    busRd = 1'b1; busRmw = rmw;
    #1 v = busRdData;
    busRd = 1'b0; busRmw = 1'b0;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    rstN = 1'b0; busWrByte = 0; busWrBit = 0; busBitSel = 0; busWrData = 0;
    cfgWr = 0; busRd = 0; busRmw = 0; pinIn = 8'h00;
    periphSel = 8'hFF; periphOut = 8'h00; analogSel = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, crossbar off so periphSel is ignored
    check("R1 padOut", padOut, 8'hFF);
    check("R1 pullupEn", pullupEn, 8'hFF);
    check("R1 padOe", padOe, 8'hFF);
    readPort(1'b1, r);
    check("R1 latch", r, 8'hFF);
    periphSel = 8'h00;

    // R11: idle read data
    check("R11 idle", busRdData, 8'h00);

    // Vector table: R2, R4, R5, R6, R8, R9
    foreach (VEC[i]) begin
      byteWrite(VEC[i][31:24]);
      pinIn = VEC[i][23:16]; analogSel = VEC[i][15:8];
      #1;
      readPort(1'b0, r);
      check("R4/R5 pad read", r, VEC[i][7:0]);
      readPort(1'b1, r);
      check("R2/R6 latch read", r, VEC[i][31:24]);
      check("R8/R5 padOut", padOut, VEC[i][31:24] & ~VEC[i][15:8]);
      check("R5 padOe", padOe, ~VEC[i][15:8]);
      check("R9 pullupEn", pullupEn, ~VEC[i][15:8]);
    end
    analogSel = 8'h00;

    // R3: bit write clears bit 3 only
    byteWrite(8'hFF);
    @(negedge clk);
    busWrBit = 1'b1; busBitSel = 3'd3; busWrData = 8'h00;
    @(negedge clk);
    busWrBit = 1'b0;
    check("R3 bit clear", padOut, 8'hF7);
    // R3: bit write sets bit 6, data bits above 0 ignored
    @(negedge clk);
    busWrBit = 1'b1; busBitSel = 3'd6; busWrData = 8'h01;
    @(negedge clk);
    busWrBit = 1'b0;
    check("R3 bit set", padOut, 8'hF7);
    byteWrite(8'h00);
    @(negedge clk);
    busWrBit = 1'b1; busBitSel = 3'd6; busWrData = 8'hFF;
    @(negedge clk);
    busWrBit = 1'b0;
    check("R3 bit set 6", padOut, 8'h40);
    // R3: byte write wins over bit write
    @(negedge clk);
    busWrBit = 1'b1; busWrByte = 1'b1; busBitSel = 3'd0; busWrData = 8'h12;
    @(negedge clk);
    busWrBit = 1'b0; busWrByte = 1'b0;
    check("R3 byte priority", padOut, 8'h12);

    // R2: latch holds without write
    busWrData = 8'hEE;
    repeat (2) @(negedge clk);
    check("R2 hold", padOut, 8'h12);

    // R10/R7: crossbar on
    byteWrite(8'hF7);
    periphSel = 8'h0F; periphOut = 8'h05;
    #1 check("R8 xbar off ignores periph", padOut, 8'hF7);
    cfgWrite(8'h01);
    check("R7/R10 xbar on", padOut, 8'hF5);
    pinIn = 8'h99;
    readPort(1'b0, r);
    check("R4 pad read with periph", r, 8'h99);
    byteWrite(8'h00);
    check("R7 periph pads", padOut, 8'h05);
    readPort(1'b1, r);
    check("R7 latch updated", r, 8'h00);

    // R6: read-modify-write: latch read then write next cycle (XOR 0x3C)
    pinIn = 8'hFF;
    @(negedge clk);
    readPort(1'b1, r);
    @(negedge clk);
    busWrByte = 1'b1; busWrData = r ^ 8'h3C;
    @(negedge clk);
    busWrByte = 1'b0;
    readPort(1'b1, r);
    check("R6 rmw result", r, 8'h3C);

    // R10/R8: crossbar off again
    cfgWrite(8'h00);
    check("R8 xbar off", padOut, 8'h3C);

    // R9/R10: pullup disable
    analogSel = 8'h11;
    cfgWrite(8'h02);
    check("R9 pullups off", pullupEn, 8'h00);
    cfgWrite(8'h00);
    check("R9 pullups on", pullupEn, 8'hEE);

    // R11: idle read after activity
    #1 check("R11 idle end", busRdData, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule